// File: doc/BRIEF.md
# Ingress QoS Priority Classifier

This block gives each received frame of a multi-port switch an internal 3-bit priority and a 2-bit drop color. A header parser upstream presents the fields it has already extracted from the frame:
- whether a DSCP value is present, and the value;
- whether a customer VLAN tag (C-tag) is present, with its PCP and DEI bits;
- whether a service VLAN tag (S-tag) is present, with its PCP and DEI bits;
- the ingress port number.

The block registers its decision and presents it with a valid strobe one cycle later.

Software configures the block through a plain register write/read bus. The bus reaches these tables:
- a DSCP-to-priority table that all ports share;
- a two-bank PCP/DEI table that yields both a priority and a color;
- a default-priority register for each port;
- a precedence register for each port, holding one 3-bit field for every priority source.

For each frame, the source with the highest precedence among those that apply to it decides the result. Setting a field to zero makes the port ignore that source. Four source slots are reserved for lookups that live outside this block (source MAC, destination MAC, VLAN ID and ACL). They never match here.

Top module: `qos_prio_classifier`

## Requirements
- R1: One cycle after a clock edge that samples `req_valid` high, `out_valid` is high and `out_prio`/`out_color` hold the result for that request. `out_valid` is low in the cycle after an edge that samples `req_valid` low.
- R2: The DSCP table has 64 entries shared by all ports, at address 0x00+dscp, with the priority in data bits 2:0. The DSCP source applies only when `dscp_valid` is high.
- R3: The PCP table has 32 entries at address 0x40 + 16*bank + 8*dei + pcp. Each entry holds the priority in bits 4:2 and the color in bits 1:0. C-tag lookups use the bank in bit 5 of the port's QoS register. S-tag lookups use the bank in bit 4. Each tag source applies only when its tag is present.
- R4: The color encoding is green 0, yellow 1, red 2. The output color is green unless a PCP source (C-tag or S-tag) wins.
- R5: Each port has a QoS register at address 0x60+port. Bit 0 enables the port default and bits 3:1 hold the default priority. The port-default source applies exactly when bit 0 is set.
- R6: Each port has a precedence register at address 0x70+port, with a 3-bit field for source m at bits 3m+2:3m. The sources are:
  - 0: MAC SA
  - 1: MAC DA
  - 2: VID
  - 3: ACL
  - 4: DSCP
  - 5: C-tag PCP
  - 6: S-tag PCP
  - 7: port default

  A field value of 0 disables sources 0 to 6. Source 7 uses its own field only as its precedence.
- R7: Among the sources that apply, the one with the largest precedence value wins. A tie goes to the higher source index.
- R8: Sources 0 to 3 never match, whatever their precedence fields hold.
- R9: After reset, these registers and tables hold 0:
  - every precedence register;
  - every QoS register;
  - every DSCP entry.

  Each PCP entry resets to priority = pcp, with color yellow when dei = 1 and green when dei = 0.
- R10: When no source applies, the output is priority 0, green.
- R11: A read returns the last value written, masked to the field width: 3 bits for DSCP entries, 5 for PCP entries, 6 for QoS registers and 24 for precedence registers. Reads of addresses outside the map return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address (write and read) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| req_valid | input | 1 | Classification request strobe |
| req_port | input | PORT_W | Ingress port number |
| req_dscp_valid | input | 1 | Frame carries a DSCP value |
| req_dscp | input | 6 | DSCP value |
| req_ctag | input | 1 | C-tag present |
| req_ctag_pcp | input | 3 | C-tag PCP |
| req_ctag_dei | input | 1 | C-tag DEI |
| req_stag | input | 1 | S-tag present |
| req_stag_pcp | input | 3 | S-tag PCP |
| req_stag_dei | input | 1 | S-tag DEI |
| out_valid | output | 1 | Result strobe |
| out_prio | output | 3 | Resolved internal priority |
| out_color | output | 2 | Resolved drop color |

## Verification
The bench builds the block with NUM_PORTS = 6, which is not a power of two. With that value, addresses 0x66–0x6F and 0x76–0x7F decode to no port. The bench can then show that writes to those addresses are dropped and that reads return zero.

Six ports also give the random mix enough distinct precedence and QoS registers to cover several cases:
- ties between sources;
- disabled sources;
- both PCP table banks, alongside the shared DSCP table.

// File: rtl/qos_pkg.sv
package qos_pkg;
    localparam int NUM_SRC  = 8;
    localparam int ORD_W    = 3;
    localparam int PRIO_W   = 3;
    localparam int COLOR_W  = 2;
    localparam int DSCP_N   = 64;
    localparam int PCP_N    = 32;
    localparam int QOS_W    = 6;
    localparam int ORD_REG_W = NUM_SRC * ORD_W;

    localparam int SRC_DSCP = 4;
    localparam int SRC_CTAG = 5;
    localparam int SRC_STAG = 6;
    localparam int SRC_PORT = 7;

    localparam logic [1:0] COLOR_GREEN  = 2'd0;
    localparam logic [1:0] COLOR_YELLOW = 2'd1;
    localparam logic [1:0] COLOR_RED    = 2'd2;

    typedef struct packed {
        logic                valid;
        logic [PRIO_W-1:0]   prio;
        logic [COLOR_W-1:0]  color;
    } qos_result_t;
endpackage

// File: rtl/qos_cfg_store.sv
module qos_cfg_store
    import qos_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [5:0]            dscp_idx,
    output logic [PRIO_W-1:0]     dscp_prio,
    input  logic [PORT_W-1:0]     port_sel,
    output logic [QOS_W-1:0]      qos_out,
    output logic [ORD_REG_W-1:0]  ord_out,
    input  logic [4:0]            ctag_idx,
    output logic [4:0]            ctag_entry,
    input  logic [4:0]            stag_idx,
    output logic [4:0]            stag_entry
);
    typedef struct packed {
        logic [DSCP_N-1:0][PRIO_W-1:0]     dscp;
        logic [PCP_N-1:0][4:0]             pcp;
        logic [NUM_PORTS-1:0][QOS_W-1:0]   qos;
        logic [NUM_PORTS-1:0][ORD_REG_W-1:0] ord;
    } cfg_t;

    cfg_t st_d, st_q;

    function automatic logic [PCP_N-1:0][4:0] pcp_reset();
        logic [PCP_N-1:0][4:0] tbl;
        for (int i = 0; i < PCP_N; i++) begin
            logic [4:0] iv;
            iv = 5'(i);
            tbl[i] = {iv[2:0], 1'b0, iv[3]};
        end
        return tbl;
    endfunction

    logic hit_dscp, hit_pcp, hit_qos, hit_ord, port_ok;
    logic [PORT_W-1:0] a_port;

    always_comb begin
        a_port   = addr[PORT_W-1:0];
        port_ok  = 32'(addr[3:0]) < NUM_PORTS;
        hit_dscp = addr[7:6] == 2'b00;
        hit_pcp  = addr[7:5] == 3'b010;
        hit_qos  = addr[7:4] == 4'h6 && port_ok;
        hit_ord  = addr[7:4] == 4'h7 && port_ok;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (hit_dscp) st_d.dscp[addr[5:0]] = wdata[PRIO_W-1:0];
            if (hit_pcp)  st_d.pcp[addr[4:0]]  = wdata[4:0];
            if (hit_qos)  st_d.qos[a_port]     = wdata[QOS_W-1:0];
            if (hit_ord)  st_d.ord[a_port]     = wdata[ORD_REG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dscp <= '0;
            st_q.pcp  <= pcp_reset();
            st_q.qos  <= '0;
            st_q.ord  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_dscp) rdata = 32'(st_q.dscp[addr[5:0]]);
        if (hit_pcp)  rdata = 32'(st_q.pcp[addr[4:0]]);
        if (hit_qos)  rdata = 32'(st_q.qos[a_port]);
        if (hit_ord)  rdata = 32'(st_q.ord[a_port]);
    end

    always_comb begin
        dscp_prio  = st_q.dscp[dscp_idx];
        ctag_entry = st_q.pcp[ctag_idx];
        stag_entry = st_q.pcp[stag_idx];
        qos_out    = '0;
        ord_out    = '0;
        if (32'(port_sel) < NUM_PORTS) begin
            qos_out = st_q.qos[port_sel];
            ord_out = st_q.ord[port_sel];
        end
    end

    // R6
    ord_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ord) |=> st_q.ord[$past(a_port)] == $past(wdata[ORD_REG_W-1:0]));

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_dscp && !hit_pcp && !hit_qos && !hit_ord) |=> $stable(st_q));
endmodule

// File: rtl/qos_src_select.sv
module qos_src_select
    import qos_pkg::*;
(
    input  logic [NUM_SRC-1:0]              cand_en,
    input  logic [NUM_SRC-1:0][ORD_W-1:0]   cand_ord,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  cand_prio,
    input  logic [NUM_SRC-1:0][COLOR_W-1:0] cand_color,
    output logic                            win_any,
    output logic [NUM_SRC-1:0]              win_oh,
    output logic [PRIO_W-1:0]               win_prio,
    output logic [COLOR_W-1:0]              win_color
);
    logic [ORD_W-1:0] best_ord;
    logic [2:0]       best_idx;

    always_comb begin
        win_any  = 1'b0;
        best_ord = '0;
        best_idx = '0;
        for (int m = 0; m < NUM_SRC; m++) begin
            if (cand_en[m] && (!win_any || cand_ord[m] >= best_ord)) begin
                win_any  = 1'b1;
                best_ord = cand_ord[m];
                best_idx = 3'(m);
            end
        end
        win_oh    = '0;
        win_prio  = '0;
        win_color = COLOR_GREEN;
        if (win_any) begin
            win_oh[best_idx] = 1'b1;
            win_prio         = cand_prio[best_idx];
            win_color        = cand_color[best_idx];
        end
    end
endmodule

// File: rtl/qos_prio_classifier.sv
module qos_prio_classifier
    import qos_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [7:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               req_valid,
    input  logic [PORT_W-1:0]  req_port,
    input  logic               req_dscp_valid,
    input  logic [5:0]         req_dscp,
    input  logic               req_ctag,
    input  logic [2:0]         req_ctag_pcp,
    input  logic               req_ctag_dei,
    input  logic               req_stag,
    input  logic [2:0]         req_stag_pcp,
    input  logic               req_stag_dei,
    output logic               out_valid,
    output logic [2:0]         out_prio,
    output logic [1:0]         out_color
);
    logic [PRIO_W-1:0]    dscp_prio;
    logic [QOS_W-1:0]     qos_cur;
    logic [ORD_REG_W-1:0] ord_cur;
    logic [4:0]           ctag_idx, stag_idx, ctag_entry, stag_entry;

    assign ctag_idx = {qos_cur[5], req_ctag_dei, req_ctag_pcp};
    assign stag_idx = {qos_cur[4], req_stag_dei, req_stag_pcp};

    qos_cfg_store #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .dscp_idx   (req_dscp),
        .dscp_prio  (dscp_prio),
        .port_sel   (req_port),
        .qos_out    (qos_cur),
        .ord_out    (ord_cur),
        .ctag_idx   (ctag_idx),
        .ctag_entry (ctag_entry),
        .stag_idx   (stag_idx),
        .stag_entry (stag_entry)
    );

    logic [NUM_SRC-1:0]              cand_en;
    logic [NUM_SRC-1:0][ORD_W-1:0]   cand_ord;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  cand_prio;
    logic [NUM_SRC-1:0][COLOR_W-1:0] cand_color;

    for (genvar m = 0; m < NUM_SRC; m++) begin : g_ord
        assign cand_ord[m] = ord_cur[m*ORD_W +: ORD_W];
    end

    always_comb begin
        cand_en    = '0;
        cand_prio  = '0;
        cand_color = '0;
        // sources 0..3 are external lookups: never match here (R8)
        cand_en[SRC_DSCP]    = req_dscp_valid && cand_ord[SRC_DSCP] != '0;
        cand_prio[SRC_DSCP]  = dscp_prio;
        cand_en[SRC_CTAG]    = req_ctag && cand_ord[SRC_CTAG] != '0;
        cand_prio[SRC_CTAG]  = ctag_entry[4:2];
        cand_color[SRC_CTAG] = ctag_entry[1:0];
        cand_en[SRC_STAG]    = req_stag && cand_ord[SRC_STAG] != '0;
        cand_prio[SRC_STAG]  = stag_entry[4:2];
        cand_color[SRC_STAG] = stag_entry[1:0];
        cand_en[SRC_PORT]    = qos_cur[0];
        cand_prio[SRC_PORT]  = qos_cur[3:1];
    end

    logic                win_any;
    logic [NUM_SRC-1:0]  win_oh;
    logic [PRIO_W-1:0]   win_prio;
    logic [COLOR_W-1:0]  win_color;

    qos_src_select u_sel (
        .cand_en    (cand_en),
        .cand_ord   (cand_ord),
        .cand_prio  (cand_prio),
        .cand_color (cand_color),
        .win_any    (win_any),
        .win_oh     (win_oh),
        .win_prio   (win_prio),
        .win_color  (win_color)
    );

    qos_result_t res_d, res_q;

    always_comb begin
        res_d.valid = req_valid;
        res_d.prio  = res_q.prio;
        res_d.color = res_q.color;
        if (req_valid) begin
            res_d.prio  = win_prio;
            res_d.color = win_color;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_prio  = res_q.prio;
    assign out_color = res_q.color;

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R1
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R7
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh) && (win_any == (cand_en != '0)));
    // R4
    color_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_color != COLOR_GREEN) |-> (win_oh[SRC_CTAG] || win_oh[SRC_STAG]));
    // R8
    ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_oh[3:0] == 4'b0000);
    // R5
    port_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_oh[SRC_PORT] |-> qos_cur[0]);
endmodule

// File: tb/tb_qos_prio_classifier.sv
module tb_qos_prio_classifier;
    localparam int NP = 6;
    localparam int PW = $clog2(NP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic req_valid = 1'b0;
    logic [PW-1:0] req_port = '0;
    logic req_dscp_valid = 1'b0;
    logic [5:0] req_dscp = '0;
    logic req_ctag = 1'b0, req_ctag_dei = 1'b0, req_stag = 1'b0, req_stag_dei = 1'b0;
    logic [2:0] req_ctag_pcp = '0, req_stag_pcp = '0;
    logic out_valid;
    logic [2:0] out_prio;
    logic [1:0] out_color;

    always #10 clk = ~clk;

    qos_prio_classifier #(.NUM_PORTS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_port(req_port), .req_dscp_valid(req_dscp_valid), .req_dscp(req_dscp),
        .req_ctag(req_ctag), .req_ctag_pcp(req_ctag_pcp), .req_ctag_dei(req_ctag_dei),
        .req_stag(req_stag), .req_stag_pcp(req_stag_pcp), .req_stag_dei(req_stag_dei),
        .out_valid(out_valid), .out_prio(out_prio), .out_color(out_color));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0]  sh_dscp [64];
    logic [4:0]  sh_pcp  [32];
    logic [5:0]  sh_qos  [NP];
    logic [23:0] sh_ord  [NP];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 64; i++) sh_dscp[i] = 3'd0;
        for (int i = 0; i < 32; i++) sh_pcp[i] = 5'((i % 8) * 4 + ((i / 8) % 2));
        for (int p = 0; p < NP; p++) begin sh_qos[p] = '0; sh_ord[p] = '0; end
    endfunction

    function automatic int model_read(input int a);
        if (a < 64) return int'(sh_dscp[a]);
        if (a >= 8'h40 && a < 8'h60) return int'(sh_pcp[a - 8'h40]);
        if (a >= 8'h60 && a < 8'h60 + NP) return int'(sh_qos[a - 8'h60]);
        if (a >= 8'h70 && a < 8'h70 + NP) return int'(sh_ord[a - 8'h70]);
        return 0;
    endfunction

    // returns {prio, color}
    function automatic logic [4:0] model_class(input int p, input bit dv, input int dscp,
        input bit ct, input int cpcp, input bit cdei, input bit st, input int spcp, input bit sdei);
        bit found = 1'b0;
        int best = 0;
        logic [4:0] r = 5'd0;
        for (int m = 4; m < 8; m++) begin
            int o = int'((sh_ord[p] >> (3 * m)) & 24'h7);
            bit app = 1'b0;
            logic [4:0] v = 5'd0;
            case (m)
                4: begin app = dv && o != 0; v = {sh_dscp[dscp], 2'b00}; end
                5: begin app = ct && o != 0;
                         v = sh_pcp[16 * int'(sh_qos[p][5]) + 8 * int'(cdei) + cpcp]; end
                6: begin app = st && o != 0;
                         v = sh_pcp[16 * int'(sh_qos[p][4]) + 8 * int'(sdei) + spcp]; end
                default: begin app = sh_qos[p][0]; v = {sh_qos[p][3:1], 2'b00}; end
            endcase
            if (app && (!found || o >= best)) begin found = 1'b1; best = o; r = v; end
        end
        return r;
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a < 64) sh_dscp[a] = 3'(d);
        else if (a >= 8'h40 && a < 8'h60) sh_pcp[a - 8'h40] = 5'(d);
        else if (a >= 8'h60 && a < 8'h60 + NP) sh_qos[a - 8'h60] = 6'(d);
        else if (a >= 8'h70 && a < 8'h70 + NP) sh_ord[a - 8'h70] = 24'(d);
    endtask

    task automatic cfg_read(input int a, input string tag);
        @(negedge clk);
        cfg_addr = 8'(a);
        #2;
        chk(int'(cfg_rdata) == model_read(a), tag, int'(cfg_rdata), model_read(a));
    endtask

    task automatic classify(input int p, input bit dv, input int dscp, input bit ct, input int cpcp,
        input bit cdei, input bit st, input int spcp, input bit sdei, input string tag);
        logic [4:0] e;
        e = model_class(p, dv, dscp, ct, cpcp, cdei, st, spcp, sdei);
        @(negedge clk);
        req_valid = 1'b1; req_port = PW'(p); req_dscp_valid = dv; req_dscp = 6'(dscp);
        req_ctag = ct; req_ctag_pcp = 3'(cpcp); req_ctag_dei = cdei;
        req_stag = st; req_stag_pcp = 3'(spcp); req_stag_dei = sdei;
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid === 1'b1, "R1 valid", int'(out_valid), 1);
        chk({out_prio, out_color} === e, tag, int'({out_prio, out_color}), int'(e));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
        cfg_read(8'h70, "R9 ord reset");
        cfg_read(8'h63, "R9 qos reset");
        cfg_read(8'h05, "R9 dscp reset");
        cfg_read(8'h4D, "R9 pcp reset dei1");
        cfg_read(8'h52, "R9 pcp reset bank1");
        // R10: nothing trusted after reset
        classify(1, 1, 46, 1, 6, 1, 1, 3, 0, "R10 untrusted");
        // R5 port default only
        cfg_write(8'h60 + 2, 6'b000_1011);
        classify(2, 1, 10, 1, 7, 0, 0, 0, 0, "R5 port default");
        // R2 DSCP above port default
        cfg_write(8'h00 + 10, 6);
        cfg_write(8'h70 + 2, (3 << 12) | (1 << 21));
        classify(2, 1, 10, 0, 0, 0, 0, 0, 0, "R2 dscp wins");
        classify(2, 0, 10, 0, 0, 0, 0, 0, 0, "R2 dscp invalid");
        // R7 tie between DSCP(4) and C-tag(5): higher index wins; R4 yellow via DEI
        cfg_write(8'h70 + 2, (3 << 12) | (3 << 15) | (1 << 21));
        classify(2, 1, 10, 1, 2, 1, 0, 0, 0, "R7 tie ctag");
        // R3 bank select via QoS bit5, red color
        cfg_write(8'h40 + 16 + 8 + 2, (5 << 2) | 2);
        cfg_write(8'h60 + 2, 6'b100_101);
        classify(2, 1, 10, 1, 2, 1, 0, 0, 0, "R3 bank1 red");
        // R8 external sources never match even with max precedence
        cfg_write(8'h70 + 3, 24'o0000_7777);
        classify(3, 1, 20, 1, 4, 0, 1, 5, 0, "R8 ext sources");
        // R6 S-tag precedence above C-tag
        cfg_write(8'h70 + 3, (2 << 15) | (4 << 18));
        classify(3, 0, 0, 1, 4, 0, 1, 5, 1, "R6 stag wins");
        classify(3, 0, 0, 1, 4, 0, 0, 5, 1, "R3 stag absent");
        // R11 unmapped addresses
        cfg_write(8'h66, 6'h3F);
        cfg_read(8'h66, "R11 unmapped qos");
        cfg_write(8'h7F, 24'hFFFFFF);
        cfg_read(8'h7F, "R11 unmapped ord");
        cfg_write(8'hA5, 32'hFFFF_FFFF);
        cfg_read(8'hA5, "R11 high addr");
        cfg_write(8'h41, 32'hFFFF_FFE3);
        cfg_read(8'h41, "R11 pcp mask");
        // R1 gap: idle cycle after a request
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 idle", int'(out_valid), 0);

        for (int it = 0; it < 600; it++) begin
            int sel = int'($urandom % 5);
            if (sel < 2) begin
                int k = int'($urandom % 4);
                int a;
                case (k)
                    0: a = int'($urandom % 64);
                    1: a = 8'h40 + int'($urandom % 32);
                    2: a = 8'h60 + int'($urandom % NP);
                    default: a = 8'h70 + int'($urandom % NP);
                endcase
                cfg_write(a, int'($urandom));
                if (it % 7 == 0) cfg_read(a, "R11 random read");
            end else begin
                classify(int'($urandom % NP), 1'($urandom), int'($urandom % 64),
                         1'($urandom), int'($urandom % 8), 1'($urandom),
                         1'($urandom), int'($urandom % 8), 1'($urandom), "R7 random");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule